// File: doc/BRIEF.md
# Tunable Multi-Bit Noise-Shaping Modulator

This block requantizes a 12-bit signed sample stream to 4-bit codes. The quantization noise is pushed out of a narrow band whose centre can be moved anywhere between DC and half the sample rate. The loop is a chain of four accumulating stages. Two small resonator terms couple pairs of stages, and the quantizer output is fed back into each stage through shift-and-add weights. A downstream filter that only needs to be accurate in the chosen band can then work on 4-bit data with small multipliers.

The delay inside every stage is a tuned section. It is a first-order allpass followed by one register, and all four sections share one tuning word `c`, equal to the cosine of the desired centre frequency in radians per sample. This doubles the loop order from four to eight. The only real multiplication in the loop is by `c`. When `c` is exactly one, the loop is the low-pass prototype with its noise notch at DC.

A sample is taken on every clock edge where `in_valid` is high. The code for that sample appears on `q_out` one cycle later, with `q_valid` high.

Top module: `tunable_sdm`

## Requirements
- R1: After reset, `q_out` is 0, `q_valid` is 0, every stage state is 0, and the tuning word is unity.
- R2: `q_valid` is high exactly in the cycle after each edge that accepts a sample. `q_out` keeps its value while no sample is accepted.
- R3: The tuning word is a 14-bit two's complement value with 12 fraction bits, so unity is 4096. `c_load` replaces it at the clock edge. A sample accepted at that same edge still uses the previous word.
- R4: With the tuning word at unity, every stage behaves as a plain accumulator, s_next = sat(u + s), and the codes match the untuned prototype loop.
- R5: Loop equations, with code q and feedback v = 256*q:
  - u1 = x - v - floor(s2/16)
  - u2 = s1 - 160*q
  - u3 = s2 - 48*q - floor(s4/128)
  - u4 = s3 - 8*q
  - The quantizer reads s4 before the update.
- R6: Each tuned stage keeps an allpass output y and the previous allpass input p. For a sample it forms e = sat(u + y), then updates y to sat(floor(c*(e + y)/4096) - p) and p to e. The stage output s is y.
- R7: The code is q = floor((s4 + 128)/256), clamped to the range -8..7 and sent as 4-bit two's complement.
- R8: Every stage state saturates to the 20-bit signed range -524288..524287 instead of wrapping.
- R9: Cycles with `in_valid` low leave every loop state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept `in_sample` at this edge |
| in_sample | input | 12 | Input sample, two's complement |
| c_load | input | 1 | Load `c_value` as the tuning word |
| c_value | input | 14 | Tuning word, 2 integer and 12 fraction bits |
| q_valid | output | 1 | A new code is on `q_out` |
| q_out | output | 4 | Quantized code, two's complement |

## Verification
The bench runs an arithmetic model of the eight-state loop beside the design. With unity tuning it also runs a separate plain-accumulator model. A design whose tuned sections drift from a pure integration at c = 1 would therefore miss both models. Tuning words at 0, minus unity, about 0.707 and out-of-range values push the loop into full-scale overload. A stage that wraps instead of saturating, or a quantizer that wraps past +7 or -8, then gives codes with the wrong sign. Tuning loads that land on the same edge as a sample catch a design that applies the new word one sample early. Random gaps in `in_valid` catch states or outputs that move while no sample is accepted.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int SDM_IN_W   = 12;
  localparam int SDM_CODE_W = 4;
  localparam int SDM_ST_W   = 20;
  localparam int SDM_C_W    = 14;
  localparam int SDM_C_FRAC = 12;
  localparam int SDM_STAGES = 4;
endpackage

// File: rtl/sdm_quantizer.sv
module sdm_quantizer #(
  parameter int SW      = sdm_pkg::SDM_ST_W,
  parameter int QW      = sdm_pkg::SDM_CODE_W,
  parameter int STEP_SH = 8
) (
  input  logic [SW-1:0] y_in,
  output logic [QW-1:0] code
);
  localparam logic signed [SW:0] RND =
    {{(SW+1-STEP_SH){1'b0}}, 1'b1, {(STEP_SH-1){1'b0}}};
  localparam logic signed [SW:0] QMAXW = {{(SW+2-QW){1'b0}}, {(QW-1){1'b1}}};
  localparam logic signed [SW:0] QMINW = {{(SW+2-QW){1'b1}}, {(QW-1){1'b0}}};

  logic signed [SW:0] y_rnd;
  logic signed [SW:0] lvl;
  logic               clip_hi;
  logic               clip_lo;

  always_comb begin
    y_rnd   = {y_in[SW-1], y_in} + RND;
    lvl     = y_rnd >>> STEP_SH;
    clip_hi = (lvl > QMAXW);
    clip_lo = (lvl < QMINW);
    if (clip_hi)      code = {1'b0, {(QW-1){1'b1}}};
    else if (clip_lo) code = {1'b1, {(QW-1){1'b0}}};
    else              code = lvl[QW-1:0];
  end

  // R7: a large positive input must give a non-negative code,
  // and a large negative input a negative code
  always_comb begin
    if (clip_hi) a_r7_clip_sign_hi: assert (code[QW-1] == 1'b0);
    if (clip_lo) a_r7_clip_sign_lo: assert (code[QW-1] == 1'b1);
  end
endmodule

// File: rtl/sdm_tuned_stage.sv
module sdm_tuned_stage #(
  parameter int SW = sdm_pkg::SDM_ST_W,
  parameter int CW = sdm_pkg::SDM_C_W,
  parameter int CF = sdm_pkg::SDM_C_FRAC,
  parameter int WW = SW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [CW-1:0] c,
  input  logic signed [WW-1:0] u,
  output logic signed [SW-1:0] s
);
  localparam int PW = SW + CW + 2;
  localparam int MW = SW + CW + 1;
  localparam logic signed [PW-1:0] MAXP = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINP = {{(PW-SW+1){1'b1}}, {(SW-1){1'b0}}};
  localparam logic signed [CW-1:0] C_ONE = {{(CW-CF-1){1'b0}}, 1'b1, {CF{1'b0}}};

  function automatic logic signed [SW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXP)      return {1'b0, {(SW-1){1'b1}}};
    else if (v < MINP) return {1'b1, {(SW-1){1'b0}}};
    else               return v[SW-1:0];
  endfunction

  logic signed [SW-1:0] y_q;   // allpass output, also the stage output
  logic signed [SW-1:0] p_q;   // previous allpass input
  logic signed [SW-1:0] e;     // allpass input after saturation
  logic signed [SW:0]   ap_sum;
  logic signed [MW-1:0] prod;
  logic signed [MW-1:0] prod_sh;
  logic signed [SW-1:0] y_nxt;

  always_comb begin
    e       = clip({{(PW-WW){u[WW-1]}}, u} + {{(PW-SW){y_q[SW-1]}}, y_q});
    ap_sum  = {e[SW-1], e} + {y_q[SW-1], y_q};
    prod    = {{CW{ap_sum[SW]}}, ap_sum} * {{(SW+1){c[CW-1]}}, c};
    prod_sh = prod >>> CF;
    y_nxt   = clip({prod_sh[MW-1], prod_sh} - {{(PW-SW){p_q[SW-1]}}, p_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q <= '0;
      p_q <= '0;
    end else if (en) begin
      y_q <= y_nxt;
      p_q <= e;
    end
  end

  assign s = y_q;

  // R9: no sample, no state motion
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y_q) && $stable(p_q)));
  // R4: at unity tuning with matched states, the stage integrates exactly
  a_r4_unity_integrates: assert property (@(posedge clk) disable iff (!rst_n)
    (en && c == C_ONE && y_q == p_q) |=> (y_q == $past(e) && p_q == y_q));
endmodule

// File: rtl/tunable_sdm.sv
module tunable_sdm #(
  parameter int IN_W = sdm_pkg::SDM_IN_W,
  parameter int QW   = sdm_pkg::SDM_CODE_W,
  parameter int SW   = sdm_pkg::SDM_ST_W,
  parameter int CW   = sdm_pkg::SDM_C_W,
  parameter int CF   = sdm_pkg::SDM_C_FRAC,
  parameter int A1_SH = 4,
  parameter int A2_SH = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  input  logic            c_load,
  input  logic [CW-1:0]   c_value,
  output logic            q_valid,
  output logic [QW-1:0]   q_out
);
  localparam int NST     = sdm_pkg::SDM_STAGES;
  localparam int WW      = SW + 3;
  localparam int STEP_SH = IN_W - QW;
  localparam logic [CW-1:0] C_UNITY = {{(CW-CF-1){1'b0}}, 1'b1, {CF{1'b0}}};

  function automatic logic signed [WW-1:0] widen(input logic signed [SW-1:0] a);
    return {{(WW-SW){a[SW-1]}}, a};
  endfunction

  logic [CW-1:0]          c_q;
  logic signed [SW-1:0]   st [NST];
  logic signed [WW-1:0]   u  [NST];
  logic [QW-1:0]          q_code;
  logic signed [WW-1:0]   x_w;
  logic signed [WW-1:0]   fb;
  logic signed [WW-1:0]   fb_b2;
  logic signed [WW-1:0]   fb_b3;
  logic signed [WW-1:0]   fb_b4;

  sdm_quantizer #(.SW(SW), .QW(QW), .STEP_SH(STEP_SH)) u_quant (
    .y_in (st[NST-1]),
    .code (q_code)
  );

  always_comb begin
    x_w   = {{(WW-IN_W){in_sample[IN_W-1]}}, in_sample};
    fb    = {{(WW-QW-STEP_SH){q_code[QW-1]}}, q_code, {STEP_SH{1'b0}}};
    fb_b2 = (fb >>> 1) + (fb >>> 3);
    fb_b3 = (fb >>> 3) + (fb >>> 4);
    fb_b4 = fb >>> 5;
    u[0]  = x_w - fb - (widen(st[1]) >>> A1_SH);
    u[1]  = widen(st[0]) - fb_b2;
    u[2]  = widen(st[1]) - fb_b3 - (widen(st[3]) >>> A2_SH);
    u[3]  = widen(st[2]) - fb_b4;
  end

  for (genvar k = 0; k < NST; k++) begin : g_stage
    sdm_tuned_stage #(.SW(SW), .CW(CW), .CF(CF), .WW(WW)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .c     (c_q),
      .u     (u[k]),
      .s     (st[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q     <= C_UNITY;
      q_out   <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) q_out <= q_code;
      if (c_load)   c_q   <= c_value;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> q_valid);
  a_r2_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!q_valid && $stable(q_out)));
  a_r3_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    c_load |=> (c_q == $past(c_value)));
  a_r3_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !c_load |=> $stable(c_q));
endmodule

// File: tb/tunable_sdm_test.sv
module tunable_sdm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        c_load = 1'b0;
  logic [13:0] c_value = '0;
  logic        q_valid;
  logic [3:0]  q_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tunable_sdm uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .c_load(c_load), .c_value(c_value), .q_valid(q_valid), .q_out(q_out)
  );

  // bench model state
  longint ms[4], mp[4], pr[4];
  longint mc;
  longint exp_q, exp_pq;
  bit     proto_on;
  int     sat_hits, clip_hits;

  function automatic longint fdiv(longint a, longint d);
    longint r = a / d;
    if ((a % d) != 0 && a < 0) r = r - 1;
    return r;
  endfunction

  function automatic longint lim(longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  function automatic longint qz(longint y);
    longint t = fdiv(y + 128, 256);
    if (t > 7) return 7;
    if (t < -8) return -8;
    return t;
  endfunction

  task automatic check(string req, longint got, longint want, string what);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin ms[k] = 0; mp[k] = 0; pr[k] = 0; end
    mc = 4096; exp_q = 0; exp_pq = 0;
  endtask

  task automatic model_step(longint x);
    longint q, pq, e, ap, nx;
    longint uu[4];
    q = qz(ms[3]);
    if (q == 7 || q == -8) clip_hits++;
    uu[0] = x - q * 256 - fdiv(ms[1], 16);
    uu[1] = ms[0] - q * 160;
    uu[2] = ms[1] - q * 48 - fdiv(ms[3], 128);
    uu[3] = ms[2] - q * 8;
    for (int k = 0; k < 4; k++) begin
      e  = lim(uu[k] + ms[k]);
      ap = fdiv(mc * (e + ms[k]), 4096) - mp[k];
      nx = lim(ap);
      if (nx != ap || e != uu[k] + ms[k]) sat_hits++;
      mp[k] = e;
      ms[k] = nx;
    end
    exp_q = q;
    // plain-accumulator prototype
    pq = qz(pr[3]);
    uu[0] = x - pq * 256 - fdiv(pr[1], 16);
    uu[1] = pr[0] - pq * 160;
    uu[2] = pr[1] - pq * 48 - fdiv(pr[3], 128);
    uu[3] = pr[2] - pq * 8;
    for (int k = 0; k < 4; k++) pr[k] = lim(uu[k] + pr[k]);
    exp_pq = pq;
  endtask

  // called at a falling edge
  task automatic apply(bit v, longint x, bit ld, longint cv, string req);
    longint got;
    in_valid  = v;
    in_sample = x[11:0];
    c_load    = ld;
    c_value   = cv[13:0];
    @(posedge clk);
    if (v) model_step(x);
    if (ld) mc = cv;
    @(negedge clk);
    in_valid = 1'b0;
    c_load   = 1'b0;
    got = longint'($signed(q_out));
    check("R2", longint'(q_valid), longint'(v), "q_valid");
    check(req, got, exp_q, "q_out");
    if (proto_on && v) check("R4", got, exp_pq, "prototype code");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; c_load = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R1", longint'(q_valid), 0, "q_valid after reset");
    check("R1", longint'($signed(q_out)), 0, "q_out after reset");
  endtask

  function automatic longint tri_wave(int n, longint amp, int per);
    int ph = n % per;
    int h = per / 2;
    if (ph < h) return -amp + (2 * amp * ph) / h;
    return amp - (2 * amp * (ph - h)) / h;
  endfunction

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit gap;
    sat_hits = 0; clip_hits = 0; proto_on = 1'b0;
    @(negedge clk);
    do_reset();

    // R4: unity word (reset default, R1/R3) must match the plain prototype
    proto_on = 1'b1;
    for (int n = 0; n < 500; n++) apply(1'b1, tri_wave(n, 1000, 64), 1'b0, 0, "R4");
    // R9 and R2: random gaps at unity
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gap = lfsr[0] & lfsr[3];
      apply(!gap, tri_wave(n, 1500, 40), 1'b0, 0, "R9");
    end
    proto_on = 1'b0;

    // R6/R5: centre at a quarter of the sample rate
    do_reset();
    apply(1'b0, 0, 1'b1, 0, "R3");
    for (int n = 0; n < 500; n++) apply(1'b1, tri_wave(n, 900, 4), 1'b0, 0, "R6");

    // R5: centre at half the sample rate, alternating input
    do_reset();
    apply(1'b0, 0, 1'b1, -4096, "R3");
    for (int n = 0; n < 300; n++) apply(1'b1, (n % 2 == 0) ? 1200 : -1200, 1'b0, 0, "R5");

    // R3: word loaded on the same edge as a sample
    do_reset();
    for (int n = 0; n < 500; n++)
      apply(1'b1, tri_wave(n, 1100, 8), (n % 50 == 10), (n % 100 == 10) ? 2896 : -1500, "R3");

    // R8: out-of-range tuning drives the loop into saturation
    do_reset();
    for (int n = 0; n < 300; n++)
      apply(1'b1, (n % 3 == 0) ? 2047 : -2048, (n % 60 == 0),
            (n % 120 == 0) ? 8191 : -8192, "R8");

    // R7: full-scale DC overloads the quantizer
    do_reset();
    for (int n = 0; n < 200; n++) apply(1'b1, 2047, 1'b0, 0, "R7");
    for (int n = 0; n < 200; n++) apply(1'b1, -2048, 1'b0, 0, "R7");
    for (int n = 0; n < 10; n++) apply(1'b0, 0, 1'b0, 0, "R9");

    check("R8", longint'(sat_hits > 0), 1, "saturation exercised");
    check("R7", longint'(clip_hits > 0), 1, "clamp exercised");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule